// File: doc/BRIEF.md
# Fixed-Interval Periodic Pulse Generator

This block drives up to three periodic pulse lines from a nanosecond time value that is kept elsewhere. Each channel has its own interval and pulse width. Once enabled, a channel fires each time the time value passes its next target, and then moves the target forward by one interval. Pulses therefore stay locked to absolute time, even when the time value advances by more than one unit per tick.

A shared prescaler must hold an even value. It divides the tick strobe into a slower phase strobe. A start-select bit can hold a newly enabled channel until the next phase strobe, so that several channels share a phase. A per-channel sync bit makes the width count phase strobes instead of ticks. Each firing sets a sticky event flag, which is masked by a per-channel enable. The first two channels can be looped back onto the trigger-capture inputs.

Software reconfigures a channel in a fixed order: set its disable bit, write its interval, width and sync fields, then clear the disable bit.

Top module: `fixed_pulse_gen`

## Requirements
- R1: Channel control is at address 0. Channel n uses bits 8n+0 (disable), 8n+5..8n+1 (width) and 8n+6 (sync). After reset every channel is disabled, and all outputs (pulse_o, evt_o, trig_lb_o, presc_err_o) are low.
- R2: Once armed, a channel's rising edges are spaced by one interval. If the time value advances by S per tick and S divides the interval P, the spacing is P/S ticks.
- R3: With sync clear, each pulse is high for width+1 ticks.
- R4: A write that sets a channel's disable bit drives its pulse low by the second clock edge after the write edge. The pending target is discarded, so no pulse appears while the channel stays disabled.
- R5: With start-select clear, a channel arms on the first tick after its disable bit is cleared, with target = time + interval. If the write lands at edge E and the time value advances by S every cycle, the pulse is first seen high P/S+1 cycles after E.
- R6: With start-select set (address 1, bit 0), arming waits for the next prescaler phase strobe.
- R7: With sync set, the width counts phase strobes. A pulse that fires on a phase strobe stays high for (width+1)×prescale ticks.
- R8: The prescale register (address 2, reset 2) accepts only even, non-zero values. Any other write leaves the register unchanged and raises presc_err_o. A legal write clears presc_err_o.
- R9: A firing sets the channel's status flag. evt_o is that flag ANDed with the interrupt enable bit (address 3, bit n). Writing 1 to bit n at address 4 clears the flag; a firing in the same cycle takes priority.
- R10: Loopback bits at address 1 (bit 1 for channel 0, bit 2 for channel 1) pass that channel's pulse to trig_lb_o. A clear bit keeps the line low.
- R11: A pulse only starts on a cycle with tick_i high. While tick_i is low, no channel fires, even if the time value passes its target.
- R12: Channel n's interval register is at address 8+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | TW | Synchronized nanosecond time |
| tick_i | input | 1 | Tick strobe; channel logic advances only on it |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| pulse_o | output | NCH | Pulse lines |
| evt_o | output | NCH | Masked event flags |
| trig_lb_o | output | 2 | Loopback to the trigger-capture inputs |
| presc_err_o | output | 1 | A rejected prescale write was seen |

## Verification
A register write takes effect at the edge that samples it. The channel sees the new field one edge later, so a pulse first shows P/S+1 cycles after an enabling write, and a disable shows low at the second negedge after the write edge. Flags and loopback are combinational on registered state, so they are checked on the same negedge where the pulse is first seen high. The bench drives and samples on falling edges. It measures high and low run lengths in whole cycles and compares them with widths and intervals computed from the requirements.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_TCTRL = 1;
  localparam int ADDR_PRSC  = 2;
  localparam int ADDR_IEN   = 3;
  localparam int ADDR_STAT  = 4;
  localparam int ADDR_PER0  = 8;
  localparam int CH_STRIDE  = 8;
  localparam int PW_W       = 5;
  localparam int OFS_DIS    = 0;
  localparam int OFS_PW     = 1;
  localparam int OFS_SYNC   = 6;
  localparam int N_LB       = 2;
endpackage

// File: rtl/ppg_regs.sv
`timescale 1ns/1ps
module ppg_regs import ppg_pkg::*; #(
  parameter int NCH    = 3,
  parameter int TW     = 32,
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int PRSC_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [NCH-1:0]               fire_i,
  output logic [NCH-1:0]               dis_o,
  output logic [NCH-1:0]               sync_o,
  output logic [NCH-1:0][PW_W-1:0]     width_o,
  output logic [NCH-1:0][TW-1:0]       period_o,
  output logic                         start_sel_o,
  output logic [N_LB-1:0]              lb_o,
  output logic [PRSC_W-1:0]            prsc_o,
  output logic [NCH-1:0]               ien_o,
  output logic [NCH-1:0]               stat_o,
  output logic                         presc_err_o
);
  logic wr_ctrl, wr_tctrl, wr_prsc, wr_ien, wr_stat, prsc_ok;
  logic [NCH-1:0] clr;

  assign wr_ctrl  = we_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_tctrl = we_i && (addr_i == AW'(ADDR_TCTRL));
  assign wr_prsc  = we_i && (addr_i == AW'(ADDR_PRSC));
  assign wr_ien   = we_i && (addr_i == AW'(ADDR_IEN));
  assign wr_stat  = we_i && (addr_i == AW'(ADDR_STAT));
  assign prsc_ok  = !wdata_i[0] && (wdata_i[PRSC_W-1:0] != '0);
  assign clr      = wr_stat ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_o       <= '1;
      sync_o      <= '0;
      width_o     <= '0;
      period_o    <= '0;
      start_sel_o <= 1'b0;
      lb_o        <= '0;
      prsc_o      <= PRSC_W'(2);
      ien_o       <= '0;
      stat_o      <= '0;
      presc_err_o <= 1'b0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (wr_ctrl) begin
          dis_o[n]   <= wdata_i[CH_STRIDE*n + OFS_DIS];
          sync_o[n]  <= wdata_i[CH_STRIDE*n + OFS_SYNC];
          width_o[n] <= wdata_i[CH_STRIDE*n + OFS_PW +: PW_W];
        end
        if (we_i && (addr_i == AW'(ADDR_PER0 + n))) period_o[n] <= wdata_i[TW-1:0];
      end
      if (wr_tctrl) begin
        start_sel_o <= wdata_i[0];
        lb_o        <= wdata_i[N_LB:1];
      end
      if (wr_prsc) begin
        presc_err_o <= !prsc_ok;
        if (prsc_ok) prsc_o <= wdata_i[PRSC_W-1:0];
      end
      if (wr_ien) ien_o <= wdata_i[NCH-1:0];
      stat_o <= (stat_o & ~clr) | fire_i;
    end
  end
endmodule

// File: rtl/ppg_presc.sv
`timescale 1ns/1ps
module ppg_presc #(
  parameter int PRSC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [PRSC_W-1:0] prsc_i,
  output logic              pstrobe_o
);
  logic [PRSC_W-1:0] cnt_q;
  logic              wrap;

  // >= keeps the counter bounded when the divisor shrinks mid-count
  assign wrap      = (cnt_q >= prsc_i - PRSC_W'(1));
  assign pstrobe_o = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + PRSC_W'(1);
  end
endmodule

// File: rtl/ppg_chan.sv
`timescale 1ns/1ps
module ppg_chan import ppg_pkg::*; #(
  parameter int TW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dis_i,
  input  logic            sync_i,
  input  logic [PW_W-1:0] width_i,
  input  logic [TW-1:0]   period_i,
  input  logic            start_sel_i,
  input  logic [TW-1:0]   time_i,
  input  logic            tick_i,
  input  logic            pstrobe_i,
  output logic            pulse_o,
  output logic            fire_o
);
  logic            armed_q;
  logic [TW-1:0]   tgt_q, diff;
  logic [PW_W-1:0] cnt_q;
  logic            due, step;

  // signed distance tolerates time wrap-around
  assign diff   = time_i - tgt_q;
  assign due    = armed_q && !diff[TW-1];
  assign fire_o = !dis_i && tick_i && due;
  assign step   = sync_i ? pstrobe_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (dis_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (tick_i) begin
      if (!armed_q) begin
        if (!start_sel_i || pstrobe_i) begin
          armed_q <= 1'b1;
          tgt_q   <= time_i + period_i;
        end
      end else if (due) begin
        pulse_o <= 1'b1;
        cnt_q   <= width_i;
        tgt_q   <= tgt_q + period_i;
      end else if (pulse_o && step) begin
        if (cnt_q == '0) pulse_o <= 1'b0;
        else             cnt_q   <= cnt_q - PW_W'(1);
      end
    end
  end
endmodule

// File: rtl/fixed_pulse_gen.sv
`timescale 1ns/1ps
module fixed_pulse_gen import ppg_pkg::*; #(
  parameter int NCH    = 3,
  parameter int TW     = 32,
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int PRSC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TW-1:0]     time_i,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [NCH-1:0]    pulse_o,
  output logic [NCH-1:0]    evt_o,
  output logic [N_LB-1:0]   trig_lb_o,
  output logic              presc_err_o
);
  localparam int MAX_CH = DW / CH_STRIDE;
  if (NCH > MAX_CH || NCH < N_LB || TW > DW || PRSC_W > DW) begin : g_bad_cfg
    $error("fixed_pulse_gen: unsupported parameter set");
  end

  logic [NCH-1:0]           dis, sync, ien, stat, fire;
  logic [NCH-1:0][PW_W-1:0] width;
  logic [NCH-1:0][TW-1:0]   period;
  logic                     start_sel, pstrobe;
  logic [N_LB-1:0]          lb;
  logic [PRSC_W-1:0]        prsc;

  ppg_regs #(.NCH(NCH), .TW(TW), .AW(AW), .DW(DW), .PRSC_W(PRSC_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .fire_i(fire),
    .dis_o(dis), .sync_o(sync), .width_o(width), .period_o(period),
    .start_sel_o(start_sel), .lb_o(lb), .prsc_o(prsc),
    .ien_o(ien), .stat_o(stat), .presc_err_o(presc_err_o)
  );

  ppg_presc #(.PRSC_W(PRSC_W)) u_presc (
    .clk_i, .rst_ni, .tick_i, .prsc_i(prsc), .pstrobe_o(pstrobe)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ppg_chan #(.TW(TW)) u_ch (
      .clk_i, .rst_ni,
      .dis_i(dis[n]), .sync_i(sync[n]), .width_i(width[n]), .period_i(period[n]),
      .start_sel_i(start_sel), .time_i, .tick_i, .pstrobe_i(pstrobe),
      .pulse_o(pulse_o[n]), .fire_o(fire[n])
    );
  end

  assign evt_o     = stat & ien;
  assign trig_lb_o = pulse_o[N_LB-1:0] & lb;
endmodule

// File: rtl/fixed_pulse_gen_chk.sv
`timescale 1ns/1ps
module fixed_pulse_gen_chk import ppg_pkg::*; #(
  parameter int NCH    = 3,
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int PRSC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              reg_we_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [NCH-1:0]    pulse_o,
  input logic              presc_err_o,
  input logic [PRSC_W-1:0] prsc_i,
  input logic [NCH-1:0]    stat_i
);
  assert_prsc_even_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prsc_i[0] && (prsc_i != '0));

  assert_odd_flagged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(ADDR_PRSC) && reg_wdata_i[0]) |=> presc_err_o);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assert_dis_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == AW'(ADDR_CTRL) && reg_wdata_i[CH_STRIDE*n + OFS_DIS])
      |=> ##1 !pulse_o[n]);

    assert_rise_on_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pulse_o[n]) |-> $past(tick_i));

    assert_flag_on_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pulse_o[n]) |-> stat_i[n]);
  end
endmodule

bind fixed_pulse_gen fixed_pulse_gen_chk #(.NCH(NCH), .AW(AW), .DW(DW), .PRSC_W(PRSC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .pulse_o(pulse_o), .presc_err_o(presc_err_o), .prsc_i(prsc), .stat_i(stat)
);

// File: tb/tb_fixed_pulse_gen.sv
`timescale 1ns/1ps
module tb_fixed_pulse_gen;
  localparam int NCH = 3, TW = 32, AW = 4, DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TW-1:0]   time_q = '0;
  logic            tick = 1'b1;
  logic            we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [NCH-1:0]  pulse, evt;
  logic [1:0]      trig;
  logic            perr;
  int              step = 1;
  int              n_chk = 0, n_bad = 0;
  logic [31:0]     csh = 32'h0001_0101;

  always #10 clk = ~clk;
  always @(posedge clk) time_q <= time_q + TW'(step);

  fixed_pulse_gen #(.NCH(NCH), .TW(TW), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_q), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .pulse_o(pulse), .evt_o(evt), .trig_lb_o(trig), .presc_err_o(perr)
  );

  typedef struct packed { int ch; int per; int w; int stp; } vec_t;
  localparam vec_t VECS [4] = '{
    '{0, 40, 2, 1}, '{1, 60, 0, 3}, '{2, 100, 4, 5}, '{1, 16, 7, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_ch(input int ch, input bit dis, input int w, input bit syn);
    csh[8*ch]       = dis;
    csh[8*ch+1 +: 5] = 5'(w);
    csh[8*ch+6]     = syn;
    wr(0, csh);
  endtask

  task automatic wait_hi(input int ch, input int maxc, output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!pulse[ch] && c < maxc);
  endtask

  task automatic run_len(input int ch, input bit lvl, output int c);
    c = 1;
    forever begin
      @(negedge clk);
      if (pulse[ch] !== lvl || c > 5000) break;
      c++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c, hi, lo;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pulse == '0 && evt == '0 && trig == '0 && perr == 1'b0, "R1 reset outputs",
        int'({pulse, evt, trig, perr}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(pulse == '0, "R1 all disabled after reset", int'(pulse), 0);

    // vector table: R2 interval, R3 width, R5 first rise, R12 per-channel interval address
    foreach (VECS[i]) begin
      step = VECS[i].stp;
      wr(8 + VECS[i].ch, 32'(VECS[i].per));
      set_ch(VECS[i].ch, 1'b0, VECS[i].w, 1'b0);
      wait_hi(VECS[i].ch, 1000, c);
      chk(c == VECS[i].per / VECS[i].stp + 1, "R5 R12 first rise delay", c,
          VECS[i].per / VECS[i].stp + 1);
      run_len(VECS[i].ch, 1'b1, hi);
      run_len(VECS[i].ch, 1'b0, lo);
      chk(hi == VECS[i].w + 1, "R3 pulse width", hi, VECS[i].w + 1);
      chk(hi + lo == VECS[i].per / VECS[i].stp, "R2 interval", hi + lo,
          VECS[i].per / VECS[i].stp);
      set_ch(VECS[i].ch, 1'b1, 0, 1'b0);
    end
    step = 1;

    // R9 mask, set, W1C; R10 loopback
    wr(1, 32'h2);
    wr(8, 32'd40);
    wr(9, 32'd30);
    set_ch(1, 1'b0, 3, 1'b0);
    set_ch(0, 1'b0, 10, 1'b0);
    wait_hi(0, 200, c);
    chk(evt[0] == 1'b0, "R9 flag masked", int'(evt[0]), 0);
    chk(trig[0] == 1'b1, "R10 loopback ch0 on", int'(trig[0]), 1);
    wr(3, 32'h1);
    chk(evt[0] == 1'b1, "R9 flag visible after enable", int'(evt[0]), 1);
    wr(4, 32'h1);
    chk(evt[0] == 1'b0, "R9 write-one clear", int'(evt[0]), 0);
    wait_hi(1, 200, c);
    chk(trig[1] == 1'b0, "R10 loopback ch1 off", int'(trig[1]), 0);

    // R4 disable mid-pulse, target discarded
    wait_hi(0, 200, c);
    set_ch(0, 1'b1, 10, 1'b0);
    @(negedge clk);
    chk(pulse[0] == 1'b0, "R4 disable forces low", int'(pulse[0]), 0);
    hi = 0;
    repeat (120) begin @(negedge clk); if (pulse[0]) hi++; end
    chk(hi == 0, "R4 no pulse while disabled", hi, 0);
    set_ch(1, 1'b1, 0, 1'b0);
    wr(1, 32'h0);

    // R11 no firing without tick
    set_ch(0, 1'b0, 2, 1'b0);
    tick = 1'b0;
    hi = 0;
    repeat (100) begin @(negedge clk); if (pulse[0]) hi++; end
    chk(hi == 0, "R11 no pulse without tick", hi, 0);
    tick = 1'b1;
    set_ch(0, 1'b1, 0, 1'b0);

    // R8 prescale legality
    wr(2, 32'd6);
    chk(perr == 1'b0, "R8 even accepted", int'(perr), 0);
    wr(2, 32'd5);
    chk(perr == 1'b1, "R8 odd flagged", int'(perr), 1);

    // R6 start on phase strobe, R7 sync width; also shows 6 was kept (R8)
    wr(1, 32'h1);
    wr(8, 32'd24);
    set_ch(0, 1'b0, 1, 1'b1);
    wait_hi(0, 200, c);
    chk(c >= 25 && c <= 30, "R6 arm waits for phase strobe", c, 25);
    run_len(0, 1'b1, hi);
    chk(hi == 12, "R7 R8 sync width with prescale 6", hi, 12);
    set_ch(0, 1'b1, 0, 1'b0);
    wr(1, 32'h0);

    wr(2, 32'd0);
    chk(perr == 1'b1, "R8 zero flagged", int'(perr), 1);
    wr(2, 32'd4);
    chk(perr == 1'b0, "R8 legal write clears flag", int'(perr), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule